// File: doc/BRIEF.md
# Rollback-Capable Input Flit Buffer

This block is the input-side flit store of one port of a wormhole router. Incoming flits are written at a tail pointer. The routing and crossbar pipeline reads the flit at a head pointer and takes it with a grant strobe. A flit that has been taken is not freed straight away. It stays in the buffer until a confirmation window has elapsed, long enough for the downstream integrity check to pass it. A third pointer, the recovery pointer, marks the oldest flit that has not yet been confirmed.

When the chip-wide error-detect input asserts, the block flushes its record of pending confirmations. It then moves the head pointer back to the recovery pointer, so every flit whose delivery was not confirmed is routed again. Storage is reclaimed only when the recovery pointer advances. Free space is therefore measured from the recovery pointer to the tail, and the write port applies backpressure on that basis.

Top module: `flit_replay_buffer`

## Requirements
- R1: After reset, wr_ready is 1 and rd_valid is 0 (the buffer holds no flits).
- R2: rd_data shows the oldest flit that has been written but not yet taken, and rd_valid is 1 exactly when such a flit exists. A cycle in which grant and rd_valid are both 1 and err_detect is 0 takes that flit, and flits come out in write order.
- R3: wr_ready is 0 exactly when DEPTH flits lie between the recovery pointer and the tail. A write offered while wr_ready is 0 is dropped and never appears on rd_data.
- R4: A taken flit keeps its slot occupied until the fourth rising edge after the edge on which it was taken. At that fourth edge the recovery pointer moves past it, which frees exactly one slot (visible on wr_ready when the buffer was full).
- R5: On a rising edge where err_detect is 1, the head pointer is reloaded from the recovery pointer. The flits that were taken but not yet confirmed then appear again on rd_data in their original order.
- R6: An error discards every take that is still awaiting confirmation, and the recovery pointer does not move on that edge. The discarded takes never free a slot later.
- R7: A write offered with wr_ready 1 in the same cycle as err_detect is accepted. It is later read out after the replayed flits.
- R8: A grant is ignored when rd_valid is 0 or when err_detect is 1; neither the head pointer nor the confirmation window changes.
- R9: Each pointer carries one wrap bit above the index bits, so full and empty stay distinct across any number of wraps of the circular storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request for wr_data |
| wr_data | input | FLIT_W | Flit to store |
| wr_ready | output | 1 | Space available; a write is taken when wr_valid and wr_ready are both 1 |
| rd_valid | output | 1 | A flit is waiting at the head pointer |
| rd_data | output | FLIT_W | Flit at the head pointer |
| grant | input | 1 | Input controller has granted the head flit its output channel |
| err_detect | input | 1 | Chip-wide error detected; triggers rollback |

## Verification
The bench targets the full buffer whose head has been drained. If the design measured free space from the head, wr_ready would rise as soon as a grant happened instead of four edges later. Rollback is driven while takes are still in flight: a design that kept those takes would advance the recovery pointer over unconfirmed flits, skip them on replay and free slots too early. Writes coinciding with an error, grants on an empty buffer, and long runs across several wraps are also covered. These expose a design that drops the write, moves the head on an empty buffer, or confuses full with empty once the pointers wrap.

// File: rtl/fb_pkg.sv
package fb_pkg;
   // Width of a pointer with one extra wrap bit for a given depth.
   function automatic int ptr_width(input int depth);
      return $clog2(depth) + 1;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/fb_store.sv
module fb_store #(
   parameter int FLIT_W = 32,
   parameter int DEPTH  = 8,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     wr_idx,
   input  logic [FLIT_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_idx,
   output logic [FLIT_W-1:0] rd_data
);
   logic [FLIT_W-1:0] slot_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) slot_q[wr_idx] <= wr_data;
   end

   assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/fb_confirm_pipe.sv
module fb_confirm_pipe #(
   parameter int LAT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic flush,
   output logic retire
);
   logic [LAT-1:0] stage_q;

   generate
      if (LAT == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n)     stage_q <= '0;
            else if (flush) stage_q <= '0;
            else            stage_q <= take;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (!rst_n)     stage_q <= '0;
            else if (flush) stage_q <= '0;
            else            stage_q <= {stage_q[LAT-2:0], take};
         end
      end
   endgenerate

   // A take leaving the last stage during a flush is discarded.
   assign retire = stage_q[LAT-1] & ~flush;
endmodule

// File: rtl/fb_pointers.sv
module fb_pointers #(
   parameter int DEPTH = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int PW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          take,
   input  logic          retire,
   input  logic          rollback,
   output logic          wr_ready,
   output logic          rd_valid,
   output logic [AW-1:0] wr_idx,
   output logic [AW-1:0] rd_idx,
   output logic [PW-1:0] tail_ptr,
   output logic [PW-1:0] head_ptr,
   output logic [PW-1:0] rec_ptr
);
   logic [PW-1:0] tail_q, head_q, rec_q;
   logic [PW-1:0] held;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tail_q <= '0;
         head_q <= '0;
         rec_q  <= '0;
      end else begin
         if (push)          tail_q <= tail_q + PW'(1);
         if (rollback)      head_q <= rec_q;
         else if (take)     head_q <= head_q + PW'(1);
         if (retire)        rec_q  <= rec_q + PW'(1);
      end
   end

   assign held     = tail_q - rec_q;
   assign wr_ready = (held != PW'(DEPTH));
   assign rd_valid = (head_q != tail_q);
   assign wr_idx   = tail_q[AW-1:0];
   assign rd_idx   = head_q[AW-1:0];
   assign tail_ptr = tail_q;
   assign head_ptr = head_q;
   assign rec_ptr  = rec_q;
endmodule

// File: rtl/flit_replay_buffer.sv
module flit_replay_buffer #(
   parameter int FLIT_W      = 32,
   parameter int DEPTH       = 8,
   parameter int CONFIRM_LAT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [FLIT_W-1:0] wr_data,
   output logic              wr_ready,
   output logic              rd_valid,
   output logic [FLIT_W-1:0] rd_data,
   input  logic              grant,
   input  logic              err_detect
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = fb_pkg::ptr_width(DEPTH);

   generate
      if (!fb_pkg::is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
         $fatal(1, "flit_replay_buffer: DEPTH must be a power of two >= 2");
      end
      if (CONFIRM_LAT < 1) begin : g_bad_lat
         $fatal(1, "flit_replay_buffer: CONFIRM_LAT must be at least 1");
      end
      if (FLIT_W < 1) begin : g_bad_width
         $fatal(1, "flit_replay_buffer: FLIT_W must be positive");
      end
   endgenerate

   logic          push, take, retire;
   logic [AW-1:0] wr_idx, rd_idx;
   logic [PW-1:0] tail_ptr, head_ptr, rec_ptr;

   assign push = wr_valid & wr_ready;
   assign take = grant & rd_valid & ~err_detect;

   fb_pointers #(.DEPTH(DEPTH)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .take     (take),
      .retire   (retire),
      .rollback (err_detect),
      .wr_ready (wr_ready),
      .rd_valid (rd_valid),
      .wr_idx   (wr_idx),
      .rd_idx   (rd_idx),
      .tail_ptr (tail_ptr),
      .head_ptr (head_ptr),
      .rec_ptr  (rec_ptr)
   );

   fb_confirm_pipe #(.LAT(CONFIRM_LAT)) u_confirm (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (take),
      .flush  (err_detect),
      .retire (retire)
   );

   fb_store #(.FLIT_W(FLIT_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .we      (push),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );
endmodule

// File: rtl/fb_checker.sv
module fb_checker #(
   parameter int DEPTH = 8,
   localparam int PW   = $clog2(DEPTH) + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_valid,
   input logic          wr_ready,
   input logic          rd_valid,
   input logic          grant,
   input logic          err_detect,
   input logic [PW-1:0] tail_ptr,
   input logic [PW-1:0] head_ptr,
   input logic [PW-1:0] rec_ptr
);
   logic [PW-1:0] held, inflight;
   assign held     = tail_ptr - rec_ptr;
   assign inflight = head_ptr - rec_ptr;

   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |=> (tail_ptr == '0 && head_ptr == '0 && rec_ptr == '0));

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      held <= PW'(DEPTH));

   assert_head_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
      inflight <= held);

   assert_rollback_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
      err_detect |=> head_ptr == $past(rec_ptr));

   assert_flush_holds_rec_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err_detect |=> rec_ptr == $past(rec_ptr));

   assert_write_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready) |=> tail_ptr == $past(tail_ptr) + PW'(1));

   assert_idle_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && !rd_valid && !err_detect) |=> head_ptr == $past(head_ptr));
endmodule

bind flit_replay_buffer fb_checker #(.DEPTH(DEPTH)) i_fb_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_valid   (wr_valid),
   .wr_ready   (wr_ready),
   .rd_valid   (rd_valid),
   .grant      (grant),
   .err_detect (err_detect),
   .tail_ptr   (tail_ptr),
   .head_ptr   (head_ptr),
   .rec_ptr    (rec_ptr)
);

// File: tb/test_flit_replay_buffer.sv
`timescale 1ns/1ps
module test_flit_replay_buffer;
   localparam int W = 32;
   localparam int D = 8;
   localparam int L = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_valid = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         wr_ready;
   logic         rd_valid;
   logic [W-1:0] rd_data;
   logic         grant = 1'b0;
   logic         err_detect = 1'b0;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // Behavioural reference: unbounded counters, a slot array and a pending-take list.
   int            m_tail = 0, m_head = 0, m_rec = 0;
   logic [W-1:0]  m_slot [D];
   int            m_ages [$];   // edges elapsed since each outstanding take

   always #2.5 clk = ~clk;

   flit_replay_buffer #(.FLIT_W(W), .DEPTH(D), .CONFIRM_LAT(L)) i_flit_replay_buffer (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data),
      .grant(grant), .err_detect(err_detect)
   );

   task automatic check(input string req, input string what, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic bit exp_ready();
      return (m_tail - m_rec) != D;
   endfunction

   function automatic bit exp_valid();
      return m_head != m_tail;
   endfunction

   // One cycle: compare outputs against the model, drive inputs, advance the model.
   task automatic step(input bit wv, input logic [W-1:0] wd, input bit g, input bit e,
                       input string req);
      bit acc, tk;
      int retired;
      @(negedge clk);
      check(req, "wr_ready", W'(wr_ready), W'(exp_ready()));
      check(req, "rd_valid", W'(rd_valid), W'(exp_valid()));
      if (exp_valid()) check(req, "rd_data", rd_data, m_slot[m_head % D]);
      wr_valid   = wv;
      wr_data    = wd;
      grant      = g;
      err_detect = e;
      acc = wv && exp_ready();
      tk  = g && exp_valid() && !e;
      if (acc) begin
         m_slot[m_tail % D] = wd;
         m_tail++;
      end
      if (e) begin
         m_ages.delete();
         m_head = m_rec;
      end else begin
         retired = 0;
         foreach (m_ages[i]) m_ages[i]++;
         while (m_ages.size() > 0 && m_ages[0] >= L) begin
            void'(m_ages.pop_front());
            retired++;
         end
         m_rec += retired;
         if (tk) begin
            m_head++;
            m_ages.push_back(0);
         end
      end
   endtask

   task automatic idle(input int n, input string req);
      for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0, req);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check("R1", "wr_ready after reset", W'(wr_ready), W'(1));
      check("R1", "rd_valid after reset", W'(rd_valid), W'(0));

      // R2: in-order delivery with spaced grants
      for (int i = 0; i < 3; i++) step(1'b1, 32'hA000_0000 + W'(i), 1'b0, 1'b0, "R2");
      step(1'b0, '0, 1'b1, 1'b0, "R2");
      step(1'b0, '0, 1'b0, 1'b0, "R2");
      step(1'b0, '0, 1'b1, 1'b0, "R2");
      step(1'b0, '0, 1'b1, 1'b0, "R2");
      idle(6, "R2");

      // R8: grants on an empty buffer do nothing
      step(1'b0, '0, 1'b1, 1'b0, "R8");
      step(1'b0, '0, 1'b1, 1'b0, "R8");
      idle(2, "R8");

      // R3: fill past capacity; two writes are dropped
      for (int i = 0; i < D + 2; i++) step(1'b1, 32'hB000_0000 + W'(i), 1'b0, 1'b0, "R3");
      // R4: drain head while still offering writes; space returns only after confirmation
      for (int i = 0; i < D; i++) step(1'b1, 32'hC000_0000 + W'(i), 1'b1, 1'b0, "R4");
      idle(6, "R4");
      for (int i = 0; i < D; i++) step(1'b0, '0, 1'b1, 1'b0, "R4");
      idle(6, "R4");

      // R5/R6: takes in flight, then an error rewinds and discards them
      for (int i = 0; i < 3; i++) step(1'b1, 32'hD000_0000 + W'(i), 1'b0, 1'b0, "R5");
      step(1'b0, '0, 1'b1, 1'b0, "R5");
      step(1'b0, '0, 1'b1, 1'b0, "R5");
      step(1'b0, '0, 1'b1, 1'b0, "R6");
      step(1'b0, '0, 1'b1, 1'b1, "R6");
      idle(5, "R6");
      for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, 1'b0, "R5");
      idle(6, "R5");

      // R7: write in the same cycle as the error
      step(1'b1, 32'hE000_0001, 1'b0, 1'b0, "R7");
      step(1'b0, '0, 1'b1, 1'b0, "R7");
      step(1'b1, 32'hE000_0002, 1'b1, 1'b1, "R7");
      for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, 1'b0, "R7");
      idle(6, "R7");

      // R9: long mixed traffic across many wraps
      for (int i = 0; i < 400; i++)
         step((i % 3) != 0, 32'hF000_0000 + W'(i), (i % 2) == 1, (i % 37) == 20, "R9");
      idle(8, "R9");
      // R9: full again after many wraps, then empty
      for (int i = 0; i < D + 1; i++) step(1'b1, 32'h9000_0000 + W'(i), 1'b0, 1'b0, "R9");
      for (int i = 0; i < D + 1; i++) step(1'b0, '0, 1'b1, 1'b0, "R9");
      idle(6, "R9");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule